// File: doc/BRIEF.md
# RAM-Backed Fibonacci Table Filler

This block fills an on-block memory with consecutive Fibonacci terms, one term per word and one word per address, counting upward from address 0. A one-cycle start pulse launches a fill. The controller first writes the two seed terms, 0 and 1. After that it computes every further term only from words it reads back out of the memory: it fetches the two words just below the current address, adds them, and stores the sum at the current address. The fill ends with the write to a last address that the user chooses when the fill starts, and a done flag then signals the end.

The memory has a synchronous write port and a registered read port, and both ports use one clock. When the controller is idle, the read port is handed to an external address input, so the stored table can be read back one word per cycle. Sums larger than the word width wrap around, and the block raises no error for this. An asynchronous reset stops a fill in progress and clears the flags. It leaves the memory contents as they are.

Top module: `fib_ram_fill`

## Requirements
- R1: After an accepted start, address 0 is written with 0 in the first busy cycle. If the last address is at least 1, address 1 is written with 1 in the second busy cycle.
- R2: For every address n from 2 up to the last address, the stored word equals the sum of the words at n-1 and n-2.
- R3: A fill with a last address L of 2 or more keeps `busy` high for exactly 2+5*(L-1) cycles. Its final write goes to address L, `done` rises in the cycle after that write, and no address above L is written.
- R4: A last address of 0 writes only address 0 and keeps busy high for 1 cycle. A last address of 1 writes addresses 0 and 1 and keeps busy high for 2 cycles.
- R5: `done` stays high while idle until the next start pulse. An accepted start clears `done` and raises `busy` on the following clock edge. `done` and `busy` are never high together.
- R6: A start pulse while `busy` is high is ignored: the fill neither restarts nor changes its length.
- R7: An asynchronous reset (rst_n low) clears `busy` and `done` at once and leaves the memory contents unchanged.
- R8: While idle, `rd_data` shows the word stored at `rd_addr` as it was one clock edge earlier (one-cycle registered read).
- R9: Sums wrap modulo 2^DATA_WIDTH, so a stored term is the exact Fibonacci value truncated to DATA_WIDTH bits.
- R10: The last address is captured when a start is accepted. Changes on `last_addr` during a fill have no effect on that fill.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the controller and the memory |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Pulse that begins a fill; taken only while idle |
| last_addr | input | ADDR_WIDTH | Highest address the fill writes; captured at start |
| busy | output | 1 | High while a fill is in progress |
| done | output | 1 | High from the end of a fill until the next accepted start |
| rd_addr | input | ADDR_WIDTH | External read address, used while idle |
| rd_data | output | DATA_WIDTH | Registered memory read data |

## Verification
Fills are run with last addresses of 0, 1, 2, a short run, a medium run and the full 128-word depth. Each run's busy length is compared against the closed-form cycle count, which separates the seed-only paths from the read-add-write loop and catches an off-by-one in the stop test. The full-depth run goes past the 94th term, so a wrong sum width or a wrong operand order shows up as a mismatch against the truncated reference. Directed runs inject a second start, change the last address in the middle of a fill, and apply reset in the middle of a fill. Each of these shows whether the fill length, the flags and the stored words stay as required.

// File: rtl/fib_pkg.sv
package fib_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEED0,
      ST_SEED1,
      ST_RDA,
      ST_CAPA,
      ST_RDB,
      ST_CAPB,
      ST_WR
   } fill_state_t;
endpackage

// File: rtl/fib_sdp_ram.sv
module fib_sdp_ram #(
   parameter int AW = 6,
   parameter int DW = 64
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   // A read of the word being written in the same cycle returns the old contents.
   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= wdata;
      end
      rdata <= mem[raddr];
   end
endmodule

// File: rtl/fib_fill_ctrl.sv
module fib_fill_ctrl
   import fib_pkg::*;
#(
   parameter int AW = 6,
   parameter int DW = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] last_addr,
   input  logic [DW-1:0] ram_rdata,
   output logic          ram_we,
   output logic [AW-1:0] ram_waddr,
   output logic [DW-1:0] ram_wdata,
   output logic [AW-1:0] ram_raddr,
   output logic          busy,
   output logic          done,
   output logic [AW-1:0] fill_last
);
   localparam logic [AW-1:0] ONE = AW'(1);
   localparam logic [AW-1:0] TWO = AW'(2);

   fill_state_t   state;
   logic [AW-1:0] idx;
   logic [AW-1:0] last_q;
   logic [DW-1:0] opa;
   logic [DW-1:0] opb;
   logic          done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         idx    <= '0;
         last_q <= '0;
         opa    <= '0;
         opb    <= '0;
         done_q <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  last_q <= last_addr;
                  done_q <= 1'b0;
                  idx    <= '0;
                  state  <= ST_SEED0;
               end
            end
            ST_SEED0: begin
               if (last_q == '0) begin
                  done_q <= 1'b1;
                  state  <= ST_IDLE;
               end else begin
                  state <= ST_SEED1;
               end
            end
            ST_SEED1: begin
               if (last_q == ONE) begin
                  done_q <= 1'b1;
                  state  <= ST_IDLE;
               end else begin
                  idx   <= TWO;
                  state <= ST_RDA;
               end
            end
            ST_RDA:  state <= ST_CAPA;
            ST_CAPA: begin
               opa   <= ram_rdata;
               state <= ST_RDB;
            end
            ST_RDB:  state <= ST_CAPB;
            ST_CAPB: begin
               opb   <= ram_rdata;
               state <= ST_WR;
            end
            ST_WR: begin
               if (idx == last_q) begin
                  done_q <= 1'b1;
                  state  <= ST_IDLE;
               end else begin
                  idx   <= idx + ONE;
                  state <= ST_RDA;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      ram_we    = 1'b0;
      ram_waddr = idx;
      ram_wdata = opa + opb;
      ram_raddr = idx;
      unique case (state)
         ST_SEED0: begin
            ram_we    = 1'b1;
            ram_waddr = '0;
            ram_wdata = '0;
         end
         ST_SEED1: begin
            ram_we    = 1'b1;
            ram_waddr = ONE;
            ram_wdata = DW'(1);
         end
         ST_RDA:  ram_raddr = idx - TWO;
         ST_RDB:  ram_raddr = idx - ONE;
         ST_WR:   ram_we    = 1'b1;
         default: ;
      endcase
   end

   assign busy      = (state != ST_IDLE);
   assign done      = done_q;
   assign fill_last = last_q;
endmodule

// File: rtl/fib_ram_fill.sv
module fib_ram_fill #(
   parameter int ADDR_WIDTH = 6,
   parameter int DATA_WIDTH = 64
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [ADDR_WIDTH-1:0] last_addr,
   output logic                  busy,
   output logic                  done,
   input  logic [ADDR_WIDTH-1:0] rd_addr,
   output logic [DATA_WIDTH-1:0] rd_data
);
   if (ADDR_WIDTH < 2 || ADDR_WIDTH > 12) begin : g_bad_aw
      $error("fib_ram_fill: ADDR_WIDTH must lie in 2..12");
   end
   if (DATA_WIDTH < 2) begin : g_bad_dw
      $error("fib_ram_fill: DATA_WIDTH must be at least 2");
   end

   logic                  ram_we;
   logic [ADDR_WIDTH-1:0] ram_waddr;
   logic [DATA_WIDTH-1:0] ram_wdata;
   logic [ADDR_WIDTH-1:0] ctrl_raddr;
   logic [ADDR_WIDTH-1:0] ram_raddr;
   logic [DATA_WIDTH-1:0] ram_rdata;
   logic [ADDR_WIDTH-1:0] fill_last;

   fib_fill_ctrl #(.AW(ADDR_WIDTH), .DW(DATA_WIDTH)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .last_addr (last_addr),
      .ram_rdata (ram_rdata),
      .ram_we    (ram_we),
      .ram_waddr (ram_waddr),
      .ram_wdata (ram_wdata),
      .ram_raddr (ctrl_raddr),
      .busy      (busy),
      .done      (done),
      .fill_last (fill_last)
   );

   // The external read address reaches the memory only while the controller is idle.
   assign ram_raddr = busy ? ctrl_raddr : rd_addr;

   fib_sdp_ram #(.AW(ADDR_WIDTH), .DW(DATA_WIDTH)) u_ram (
      .clk   (clk),
      .we    (ram_we),
      .waddr (ram_waddr),
      .wdata (ram_wdata),
      .raddr (ram_raddr),
      .rdata (ram_rdata)
   );

   assign rd_data = ram_rdata;
endmodule

// File: rtl/fib_fill_chk.sv
module fib_fill_chk #(
   parameter int AW = 6,
   parameter int DW = 64
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          busy,
   input logic          done,
   input logic          we,
   input logic [AW-1:0] waddr,
   input logic [DW-1:0] wdata,
   input logic [AW-1:0] fill_last
);
   // R1
   seed_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (we && waddr == '0 && wdata == '0));

   // R1
   seed_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && waddr == AW'(1)) |-> (wdata == DW'(1)));

   // R3
   write_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (waddr <= fill_last));

   // R3
   done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> ($past(we) && $past(waddr) == fill_last));

   // R5
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R5
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);

   // R6
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> !(we && waddr == '0));

   // R10
   last_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> (fill_last == $past(fill_last)));
endmodule

bind fib_ram_fill fib_fill_chk #(.AW(ADDR_WIDTH), .DW(DATA_WIDTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .done      (done),
   .we        (ram_we),
   .waddr     (ram_waddr),
   .wdata     (ram_wdata),
   .fill_last (fill_last)
);

// File: tb/sim_fib_ram_fill.sv
module sim_fib_ram_fill;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 7;
   localparam int DW = 64;
   localparam int NVEC = 6;
   localparam int LASTS    [NVEC] = '{5, 0, 1, 2, 20, 127};
   localparam int EXP_BUSY [NVEC] = '{22, 1, 2, 7, 97, 632};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] last_addr = '0;
   logic          busy;
   logic          done;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   fib_ram_fill #(.ADDR_WIDTH(AW), .DATA_WIDTH(DW)) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .last_addr (last_addr),
      .busy      (busy),
      .done      (done),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [DW-1:0] fib_ref(input int n);
      logic [DW-1:0] a = '0;
      logic [DW-1:0] b = DW'(1);
      logic [DW-1:0] t;
      for (int i = 0; i < n; i++) begin
         t = a + b;
         a = b;
         b = t;
      end
      return a;
   endfunction

   task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                        input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   task automatic read_word(input int a, output logic [DW-1:0] d);
      @(negedge clk);
      rd_addr = AW'(a);
      @(negedge clk);
      d = rd_data;
   endtask

   // mode 0: plain fill, 1: extra start at busy cycle poke, 2: change last_addr at poke
   task automatic run_fill(input int last, input int poke, input int mode, output int nbusy);
      @(negedge clk);
      last_addr = AW'(last);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      nbusy = 0;
      while (busy) begin
         nbusy++;
         start = 1'b0;
         if (nbusy == poke) begin
            if (mode == 1) start = 1'b1;
            if (mode == 2) last_addr = AW'(3);
         end
         @(negedge clk);
      end
      start = 1'b0;
   endtask

   task automatic verify_table(input int last, input string tag);
      logic [DW-1:0] d;
      for (int a = 0; a <= last; a++) begin
         read_word(a, d);
         check(d == fib_ref(a), tag, d, fib_ref(a));
      end
   endtask

   initial begin
      for (int c = 0; c < 150000; c++) @(posedge clk);
      check(1'b0, "watchdog", '0, '0);
      report();
   end

   initial begin
      int nb;
      logic [DW-1:0] d;
      repeat (3) @(negedge clk);
      // R7: reset state
      check(busy == 1'b0, "R7 reset busy", DW'(busy), '0);
      check(done == 1'b0, "R7 reset done", DW'(done), '0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < NVEC; v++) begin
         run_fill(LASTS[v], 0, 0, nb);
         // R3 / R4: busy length and done at end of fill
         check(nb == EXP_BUSY[v], (LASTS[v] < 2) ? "R4 busy length" : "R3 busy length",
               DW'(nb), DW'(EXP_BUSY[v]));
         check(done == 1'b1, "R3 done after fill", DW'(done), 1);
         // R1 seeds, R2 recurrence, R8 readback, R9 wrap past term 93
         verify_table(LASTS[v], (LASTS[v] > 93) ? "R9 wrapped term" :
                                (LASTS[v] < 2) ? "R1 seed word" : "R2 term value");
      end

      // R8: registered read shows word at the previous cycle's address
      @(negedge clk);
      rd_addr = AW'(10);
      @(negedge clk);
      rd_addr = AW'(11);
      check(rd_data == fib_ref(10), "R8 read latency", rd_data, fib_ref(10));
      @(negedge clk);
      check(rd_data == fib_ref(11), "R8 read next", rd_data, fib_ref(11));

      // R5: done holds while idle, clears on start
      repeat (10) @(negedge clk);
      check(done == 1'b1, "R5 done holds", DW'(done), 1);
      last_addr = AW'(4);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(done == 1'b0, "R5 done cleared", DW'(done), 0);
      check(busy == 1'b1, "R5 busy raised", DW'(busy), 1);
      while (busy) @(negedge clk);

      // R6: extra start mid-fill ignored
      run_fill(10, 5, 1, nb);
      check(nb == 47, "R6 start ignored", DW'(nb), 47);

      // R10: last_addr change mid-fill ignored
      run_fill(10, 8, 2, nb);
      check(nb == 47, "R10 last captured", DW'(nb), 47);
      verify_table(10, "R10 table");

      // R7: reset in mid-fill, RAM kept
      @(negedge clk);
      last_addr = AW'(30);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (20) @(negedge clk);
      rst_n = 1'b0;
      #1;
      check(busy == 1'b0, "R7 async busy clear", DW'(busy), 0);
      check(done == 1'b0, "R7 async done clear", DW'(done), 0);
      @(negedge clk);
      rst_n = 1'b1;
      read_word(100, d);
      check(d == fib_ref(100), "R7 ram kept", d, fib_ref(100));
      read_word(5, d);
      check(d == fib_ref(5), "R7 ram kept low", d, fib_ref(5));

      report();
   end
endmodule